// File: doc/BRIEF.md
# Register-Controlled Reset Pulse Stretcher

This block produces three internal reset signals for the logic around it. Each one is requested through an active-low bit in a small control register that a processor writes over a simple 4-bit bus. A reset goes active in the same clock edge that clears its request bit. It does not release when the bit is set again. It stays active for a fixed number of core clock cycles and only then releases. With the default of 32 cycles at an 80 MHz core clock, this hold is 400 ns. The hold is the same however fast software toggles the bit.

A read-only status register shows which internal resets are still active. Software can poll it to see the release, so it needs no calibrated delay loop. An external synchronous reset clears the control register, so all three internal resets are active after power-up until software releases them.

Top module: `rstx_stretch`

## Requirements
- R1: While and after the external reset `rst` is applied, the control register reads 0x0, all three `int_rst` outputs are 1 and the status register reads 0x7.
- R2: A write with `bus_wr` high at address 1 stores `bus_wdata[2:0]` as the three active-low requests, where bit i drives channel i. Bit 3 is not stored and always reads 0.
- R3: A write at any address other than 1, or a cycle with `bus_wr` low, leaves the control register unchanged.
- R4: Clearing request bit i makes `int_rst[i]` 1 from the write clock edge onward, and it stays 1 while the bit is 0.
- R5: After request bit i is written from 0 to 1, `int_rst[i]` stays 1 for exactly STRETCH_CYCLES clock cycles counted from the write edge. It is 0 from the following cycle on.
- R6: If request bit i is cleared again while its hold is still counting, `int_rst[i]` stays 1, and the next 0-to-1 write starts a full hold of STRETCH_CYCLES cycles.
- R7: Reading address 5 returns {1'b0, int_rst[2:0]}, where bit i is 1 while internal reset i is active.
- R8: Reading any address other than 1 or 5 returns 0x0.
- R9: The channels are independent: releasing or asserting one request does not change the other channels' `int_rst` outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous external reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register offset, used for both write and read |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data of the register at `bus_addr`, combinational |
| int_rst | output | 3 | Stretched internal resets, active high, one per channel |

## Verification
The bench builds the block with STRETCH_CYCLES set to 6 instead of 32. With this short hold, the exact release cycle can be sampled on both sides of the boundary for every channel. The short hold also makes it practical to re-clear a request partway through a running hold and then watch the full restart. Register decoding, the unused bit and the stray-address writes are exercised the same way at any hold length, and the bound checker ties every observed release to a hold count of exactly STRETCH_CYCLES.

// File: rtl/rstx_pkg.sv
package rstx_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 4;
    localparam int NUM_CH = 3;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd1;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd5;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } rsel_t;

    function automatic rsel_t decode_addr(input logic [ADDR_W-1:0] a);
        if (a == CTRL_ADDR)      return SEL_CTRL;
        else if (a == STAT_ADDR) return SEL_STAT;
        else                     return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] widen(input logic [NUM_CH-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_CH-1:0] = v;
        return r;
    endfunction
endpackage

// File: rtl/rstx_ctrl_reg.sv
module rstx_ctrl_reg
    import rstx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [NUM_CH-1:0] ctrl_q
);
    logic hit;
    assign hit = req.wr && (decode_addr(req.addr) == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst)      ctrl_q <= '0;
        else if (hit) ctrl_q <= req.data[NUM_CH-1:0];
    end
endmodule

// File: rtl/rstx_chan.sv
module rstx_chan #(
    parameter int STRETCH_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    output logic active
);
    localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= LOAD;
        else if (!req_n)        cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active = !req_n || (cnt_q != '0);
endmodule

// File: rtl/rstx_readmux.sv
module rstx_readmux
    import rstx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] ctrl_q,
    input  logic [NUM_CH-1:0] active,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (decode_addr(addr))
            SEL_CTRL: rdata = widen(ctrl_q);
            SEL_STAT: rdata = widen(active);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/rstx_stretch.sv
module rstx_stretch
    import rstx_pkg::*;
#(
    parameter int STRETCH_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] int_rst
);
    bus_req_t          req;
    logic [NUM_CH-1:0] ctrl_q;

    assign req = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    rstx_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .ctrl_q (ctrl_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        rstx_chan #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .req_n  (ctrl_q[i]),
            .active (int_rst[i])
        );
    end

    rstx_readmux u_rd (
        .addr   (bus_addr),
        .ctrl_q (ctrl_q),
        .active (int_rst),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/rstx_stretch_chk.sv
module rstx_stretch_chk
    import rstx_pkg::*;
#(
    parameter int STRETCH_CYCLES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] int_rst,
    input logic [NUM_CH-1:0] ctrl_q
);
    localparam int HW = $clog2(STRETCH_CYCLES + 2);
    localparam logic [HW-1:0] SAT = HW'(STRETCH_CYCLES + 1);
    localparam logic [HW-1:0] HOLD = HW'(STRETCH_CYCLES);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (int_rst == '1 && ctrl_q == '0));

    assert_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == CTRL_ADDR) |=> $stable(ctrl_q));

    assert_status_read_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == STAT_ADDR) |-> (bus_rdata == widen(int_rst)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
        logic [HW-1:0] hi_cnt;
        always_ff @(posedge clk) begin
            if (rst || !ctrl_q[i])  hi_cnt <= '0;
            else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
        end

        assert_clear_asserts_R4: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[i] |-> int_rst[i]);

        assert_release_exact_R5: assert property (@(posedge clk) disable iff (rst)
            $fell(int_rst[i]) |-> (hi_cnt == HOLD));

        assert_hold_full_R6: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[i] && hi_cnt < HOLD) |-> int_rst[i]);
    end
endmodule

bind rstx_stretch rstx_stretch_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .int_rst   (int_rst),
    .ctrl_q    (ctrl_q)
);

// File: tb/rstx_stretch_tb.sv
module rstx_stretch_tb;
    localparam int S = 6;

    logic       clk = 0;
    logic       rst = 1;
    logic       bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [3:0] bus_wdata = 0;
    logic [3:0] bus_rdata;
    logic [2:0] int_rst;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rstx_stretch #(.STRETCH_CYCLES(S)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_rst(int_rst)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] waddr;
        logic [3:0] wdata;
        logic [2:0] raddr;
        logic [3:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd1, 4'hF, 3'd1, 4'h7, 4'd2},  // R2 bit 3 dropped
        '{1'b1, 3'd1, 4'h5, 3'd1, 4'h5, 4'd2},  // R2
        '{1'b1, 3'd3, 4'hA, 3'd1, 4'h5, 4'd3},  // R3 other addr
        '{1'b0, 3'd1, 4'h0, 3'd1, 4'h5, 4'd3},  // R3 no strobe
        '{1'b1, 3'd5, 4'h2, 3'd1, 4'h5, 4'd3},  // R3 status addr
        '{1'b1, 3'd1, 4'h0, 3'd1, 4'h0, 4'd2},  // R2
        '{1'b0, 3'd1, 4'h0, 3'd5, 4'h7, 4'd7},  // R7 all active
        '{1'b0, 3'd1, 4'h0, 3'd0, 4'h0, 4'd8},  // R8
        '{1'b0, 3'd1, 4'h0, 3'd7, 4'h0, 4'd8},  // R8
        '{1'b0, 3'd1, 4'h0, 3'd4, 4'h0, 4'd8}   // R8
    };

    task automatic check(input int tag, input logic [3:0] act, input logic [3:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 during and after external reset
        idle(3);
        bus_addr = 3'd1; #1;
        check(1, bus_rdata, 4'h0, "ctrl in reset");
        check(1, {1'b0, int_rst}, 4'h7, "int_rst in reset");
        rst = 0;
        idle(S + 3);
        check(1, {1'b0, int_rst}, 4'h7, "int_rst after reset");
        bus_addr = 3'd5; #1;
        check(1, bus_rdata, 4'h7, "status after reset");

        for (int v = 0; v < NV; v++) begin
            bus_op(VECS[v].wr, VECS[v].waddr, VECS[v].wdata);
            bus_addr = VECS[v].raddr; #1;
            check(int'(VECS[v].req), bus_rdata, VECS[v].exp, "table row");
        end

        // R5 exact release of all channels
        bus_op(1, 3'd1, 4'h7);
        for (int k = 0; k < S; k++) begin
            check(5, {1'b0, int_rst}, 4'h7, "held during stretch");
            if (k < S - 1) @(negedge clk);
        end
        @(negedge clk);
        check(5, {1'b0, int_rst}, 4'h0, "released after stretch");
        bus_addr = 3'd5; #1;
        check(7, bus_rdata, 4'h0, "status after release");

        // R4 clear asserts immediately; R9 others untouched
        bus_op(1, 3'd1, 4'h6);
        check(4, {1'b0, int_rst}, 4'h1, "ch0 asserted at write edge");
        check(9, {1'b0, int_rst[2:1], 1'b0}, 4'h0, "ch1/ch2 unaffected");
        bus_addr = 3'd5; #1;
        check(7, bus_rdata, 4'h1, "status ch0 only");
        idle(S + 2);
        check(4, {1'b0, int_rst}, 4'h1, "ch0 held while bit 0");

        // R9 release ch0 only while ch2 is cleared
        bus_op(1, 3'd1, 4'h3);
        check(9, {1'b0, int_rst}, 4'h5, "ch2 asserts, ch0 holds");
        idle(S - 1);
        check(9, {1'b0, int_rst}, 4'h5, "ch0 still held at S-1");
        @(negedge clk);
        check(9, {1'b0, int_rst}, 4'h4, "ch0 released, ch2 active");

        // R6 re-clear during hold restarts the full stretch
        bus_op(1, 3'd1, 4'h7);
        idle(2);
        bus_op(1, 3'd1, 4'h3);
        check(6, {1'b0, int_rst}, 4'h4, "re-cleared mid-hold");
        idle(S + 2);
        check(6, {1'b0, int_rst}, 4'h4, "stays active");
        bus_op(1, 3'd1, 4'h7);
        idle(S - 1);
        check(6, {1'b0, int_rst}, 4'h4, "full hold after restart");
        @(negedge clk);
        check(6, {1'b0, int_rst}, 4'h0, "release after restart");

        // R1 external reset reasserts everything
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        bus_addr = 3'd1; #1;
        check(1, bus_rdata, 4'h0, "ctrl cleared by reset");
        check(1, {1'b0, int_rst}, 4'h7, "all reasserted by reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule